// File: doc/BRIEF.md
# Level-to-Pulse Shared Interrupt Bridge

This block connects a bank of level-sensitive peripheral interrupt lines to a small set of edge-detecting core interrupt inputs, one input per core priority level from 7 to 15. Each peripheral request first passes through a two-flop synchronizer. It is then routed through a per-source selector and mask to one of nine core lines. When a line has an unmasked, active source, the bridge emits a single-cycle pulse on that line. It then holds the line quiet until the core acknowledges by raising its pending bit for that level.

After the acknowledge, the bridge looks at the line again. If any source routed to it is still high, it pulses once more. Requests that arrive while another request is being serviced are therefore not lost. Several peripherals can share one core line: one acknowledge re-arms them all, and one further pulse covers whichever of them are still asserted. The synchronized raw level of every source is presented on a status output, whatever its mask or routing.

Top module: `irq_pulse_bridge`

## Requirements
- R1: `src_status_o[s]` equals `irq_src_i[s]` as sampled two rising clock edges earlier, independent of mask and routing.
- R2: When a source is routed to line k and its level rises while line k is idle, `core_pulse_o[k]` goes high for exactly one clock cycle. The pulse starts on the third rising edge after the input changes.
- R3: After a pulse on line k, no further pulse appears on line k until a rising edge of `core_ack_i[k]`, however many sources on that line assert.
- R4: On a rising edge of `core_ack_i[k]` while line k waits, if an unmasked source routed to k is high, `core_pulse_o[k]` pulses on the second rising edge after the acknowledge rises.
- R5: On such an acknowledge with no active source on line k, no pulse is produced, and line k returns to idle so that a later request pulses with the R2 timing.
- R6: Sources that share one line are all re-armed by one acknowledge; if any of them is still high, one further pulse follows as in R4.
- R7: A source whose `route_mask_i` bit is 1 never causes a pulse. Clearing the mask while the source is high lets an idle line pulse on the next rising edge.
- R8: The 4-bit selector field of source s is `route_sel_i[4*s+3:4*s]`; value k in 0..8 selects line k (core level 7+k), and values 9..15 route the source to no line.
- R9: Lines are independent: an acknowledge on one line neither releases nor triggers another line.
- R10: An acknowledge on a line that is idle has no effect and produces no pulse.
- R11: While `rst_ni` is low, and after it is released, `core_pulse_o` and `src_status_o` are all zero until inputs propagate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 16 | Asynchronous level-sensitive peripheral requests |
| route_sel_i | input | 64 | Packed 4-bit line selector per source |
| route_mask_i | input | 16 | Per-source mask, 1 = blocked |
| core_ack_i | input | 9 | Core pending bit per line (levels 7..15); its rising edge acknowledges |
| core_pulse_o | output | 9 | Single-cycle request pulse per core line |
| src_status_o | output | 16 | Synchronized raw level of every source |

## Verification
The hardest case to reach is a shared line that gains a second requester while it already waits for an acknowledge. The first requester is then withdrawn before the core answers. The stimulus raises the first source and waits for its pulse. It then raises a second source on the same line and counts out several quiet cycles. Next it drops the first source and lets the synchronizer settle. Only then does it raise the acknowledge. The single re-pulse that follows can come only from the second source. A further acknowledge with both sources low must produce nothing.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;

   localparam int unsigned DEF_NUM_SRC     = 16;
   localparam int unsigned DEF_NUM_LINES   = 9;
   localparam int unsigned DEF_SEL_W       = 4;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   typedef enum logic [1:0] {
      LN_IDLE          = 2'd0,
      LN_PULSED_WAIT   = 2'd1,
      LN_REARM         = 2'd2
   } line_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2) else $fatal(1, "irq_sync: need at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q[0] <= '0;
      end else begin
         stage_q[0] <= async_i;
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[g] <= '0;
         end else begin
            stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int unsigned NUM_SRC   = 16,
   parameter int unsigned NUM_LINES = 9,
   parameter int unsigned SEL_W     = 4
) (
   input  logic [NUM_SRC-1:0]       level_i,
   input  logic [NUM_SRC*SEL_W-1:0] sel_i,
   input  logic [NUM_SRC-1:0]       mask_i,
   output logic [NUM_LINES-1:0]     line_req_o
);

   initial begin
      assert (NUM_LINES <= (1 << SEL_W))
         else $fatal(1, "irq_route: selector too narrow for line count");
   end

   logic [NUM_SRC-1:0] live;
   assign live = level_i & ~mask_i;

   logic [NUM_LINES-1:0][NUM_SRC-1:0] hit;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         localparam int unsigned LSB = s * SEL_W;
         assign hit[l][s] = live[s] && (sel_i[LSB +: SEL_W] == SEL_W'(l));
      end
      assign line_req_o[l] = |hit[l];
   end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
   import irq_bridge_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic ack_i,
   output logic pulse_o
);

   line_state_e state_q, state_d;
   logic        ack_q;
   logic        ack_rise;
   logic        pulse_d;

   assign ack_rise = ack_i & ~ack_q;

   always_comb begin
      state_d = state_q;
      pulse_d = 1'b0;
      unique case (state_q)
         LN_IDLE: begin
            if (req_i) begin
               pulse_d = 1'b1;
               state_d = LN_PULSED_WAIT;
            end
         end
         LN_PULSED_WAIT: begin
            if (ack_rise) begin
               state_d = LN_REARM;
            end
         end
         LN_REARM: begin
            if (req_i) begin
               pulse_d = 1'b1;
               state_d = LN_PULSED_WAIT;
            end else begin
               state_d = LN_IDLE;
            end
         end
         default: state_d = LN_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LN_IDLE;
         ack_q   <= 1'b0;
         pulse_o <= 1'b0;
      end else begin
         state_q <= state_d;
         ack_q   <= ack_i;
         pulse_o <= pulse_d;
      end
   end

endmodule

// File: rtl/irq_pulse_bridge.sv
module irq_pulse_bridge
   import irq_bridge_pkg::*;
#(
   parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
   parameter int unsigned NUM_LINES   = DEF_NUM_LINES,
   parameter int unsigned SEL_W       = DEF_SEL_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_SRC-1:0]       irq_src_i,
   input  logic [NUM_SRC*SEL_W-1:0] route_sel_i,
   input  logic [NUM_SRC-1:0]       route_mask_i,
   input  logic [NUM_LINES-1:0]     core_ack_i,
   output logic [NUM_LINES-1:0]     core_pulse_o,
   output logic [NUM_SRC-1:0]       src_status_o
);

   initial begin
      assert (NUM_SRC >= 1)   else $fatal(1, "irq_pulse_bridge: NUM_SRC must be >= 1");
      assert (NUM_LINES >= 1) else $fatal(1, "irq_pulse_bridge: NUM_LINES must be >= 1");
   end

   logic [NUM_SRC-1:0]   src_sync;
   logic [NUM_LINES-1:0] line_req;

   irq_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (irq_src_i),
      .sync_o  (src_sync)
   );

   irq_route #(
      .NUM_SRC   (NUM_SRC),
      .NUM_LINES (NUM_LINES),
      .SEL_W     (SEL_W)
   ) u_route (
      .level_i    (src_sync),
      .sel_i      (route_sel_i),
      .mask_i     (route_mask_i),
      .line_req_o (line_req)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      irq_line_fsm u_fsm (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .req_i   (line_req[l]),
         .ack_i   (core_ack_i[l]),
         .pulse_o (core_pulse_o[l])
      );
   end

   assign src_status_o = src_sync;

endmodule

// File: rtl/irq_pulse_bridge_chk.sv
module irq_pulse_bridge_chk #(
   parameter int unsigned NUM_SRC   = 16,
   parameter int unsigned NUM_LINES = 9,
   parameter int unsigned SEL_W     = 4
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic [NUM_SRC-1:0]       irq_src_i,
   input logic [NUM_SRC*SEL_W-1:0] route_sel_i,
   input logic [NUM_SRC-1:0]       route_mask_i,
   input logic [NUM_LINES-1:0]     core_ack_i,
   input logic [NUM_LINES-1:0]     core_pulse_o,
   input logic [NUM_SRC-1:0]       src_status_o
);

   logic [1:0]           since_rst_q;
   logic [NUM_LINES-1:0] ack_seen_q;
   logic [NUM_LINES-1:0] waiting_q;
   logic [NUM_LINES-1:0] ack_edge;

   assign ack_edge = core_ack_i & ~ack_seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_rst_q <= '0;
         ack_seen_q  <= '0;
         waiting_q   <= '0;
      end else begin
         if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
         ack_seen_q <= core_ack_i;
         waiting_q  <= (waiting_q | core_pulse_o) & ~ack_edge;
      end
   end

   AST_STATUS_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst_q == 2'd2) |-> (src_status_o == $past(irq_src_i, 2))); // R1

   AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_pulse_o & $past(core_pulse_o)) == '0); // R2

   AST_NO_PULSE_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_pulse_o & waiting_q) == '0); // R3

   AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_pulse_o != '0) |-> $past((src_status_o & ~route_mask_i) != '0)); // R7

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (core_pulse_o == '0 && src_status_o == '0)); // R11

endmodule

bind irq_pulse_bridge irq_pulse_bridge_chk #(
   .NUM_SRC   (NUM_SRC),
   .NUM_LINES (NUM_LINES),
   .SEL_W     (SEL_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .irq_src_i    (irq_src_i),
   .route_sel_i  (route_sel_i),
   .route_mask_i (route_mask_i),
   .core_ack_i   (core_ack_i),
   .core_pulse_o (core_pulse_o),
   .src_status_o (src_status_o)
);

// File: tb/irq_pulse_bridge_tb_top.sv
`timescale 1ns/1ps
module irq_pulse_bridge_tb_top;

   localparam int NS = 16;
   localparam int NL = 9;
   localparam int SW = 4;

   logic            clk = 1'b0;
   logic            rst_ni = 1'b0;
   logic [NS-1:0]   src = '0;
   logic [NS*SW-1:0] sel = '1;
   logic [NS-1:0]   mask = '0;
   logic [NL-1:0]   ack = '0;
   logic [NL-1:0]   pulse;
   logic [NS-1:0]   status;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   irq_pulse_bridge dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .irq_src_i    (src),
      .route_sel_i  (sel),
      .route_mask_i (mask),
      .core_ack_i   (ack),
      .core_pulse_o (pulse),
      .src_status_o (status)
   );

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic route(int s, int line);
      sel[s*SW +: SW] = SW'(line);
   endtask

   task automatic do_ack(logic [NL-1:0] lines);
      ack = lines;
      tick();
      ack = '0;
   endtask

   // drop every source, let the sync settle, acknowledge all lines, back to idle
   task automatic settle();
      src = '0;
      tick(3);
      do_ack('1);
      tick(2);
      check("R5 settle quiet", 32'(pulse), 0);
   endtask

   task automatic t_reset();
      check("R11 pulse in reset", 32'(pulse), 0);
      check("R11 status in reset", 32'(status), 0);
      rst_ni = 1'b1;
      tick(2);
      check("R11 pulse after reset", 32'(pulse), 0);
   endtask

   task automatic t_single();
      route(0, 2);
      src[0] = 1'b1;
      tick(2);
      check("R1 status after two edges", 32'(status), 32'h1);
      check("R2 no pulse yet", 32'(pulse), 0);
      tick();
      check("R2 pulse on line 2", 32'(pulse), 32'h4);
      tick();
      check("R2 pulse one cycle", 32'(pulse), 0);
      for (int i = 0; i < 6; i++) begin
         tick();
         check("R3 silent before ack", 32'(pulse), 0);
      end
      do_ack(9'h004);
      check("R4 no pulse one edge after ack", 32'(pulse), 0);
      tick();
      check("R4 re-pulse source still high", 32'(pulse), 32'h4);
      tick();
      check("R4 re-pulse one cycle", 32'(pulse), 0);
      src[0] = 1'b0;
      tick(3);
      check("R1 status follows fall", 32'(status), 0);
      do_ack(9'h004);
      tick();
      check("R5 no pulse without request", 32'(pulse), 0);
      tick();
      check("R5 still quiet", 32'(pulse), 0);
      src[0] = 1'b1;
      tick(3);
      check("R5 idle again, new pulse", 32'(pulse), 32'h4);
      settle();
      route(0, 15);
   endtask

   task automatic t_mask();
      route(3, 0);
      mask[3] = 1'b1;
      src[3] = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R7 masked source silent", 32'(pulse), 0);
      end
      check("R1 status shows masked source", 32'(status), 32'h8);
      mask[3] = 1'b0;
      tick();
      check("R7 unmask pulses next edge", 32'(pulse), 32'h1);
      settle();
      route(3, 15);
   endtask

   task automatic t_select();
      route(4, 9);
      route(11, 12);
      src[4] = 1'b1;
      src[11] = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R8 out-of-range selector silent", 32'(pulse), 0);
      end
      route(5, 8);
      src[5] = 1'b1;
      tick(3);
      check("R8 selector 8 drives top line", 32'(pulse), 32'h100);
      settle();
      route(4, 15);
      route(11, 15);
      route(5, 15);
   endtask

   task automatic t_shared();
      route(6, 5);
      route(7, 5);
      src[6] = 1'b1;
      tick(3);
      check("R6 first sharer pulses", 32'(pulse), 32'h20);
      src[7] = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R3 second sharer waits", 32'(pulse), 0);
      end
      src[6] = 1'b0;
      tick(3);
      do_ack(9'h020);
      tick();
      check("R6 ack re-arms, second sharer pulses", 32'(pulse), 32'h20);
      src[7] = 1'b0;
      tick(3);
      do_ack(9'h020);
      tick();
      check("R6 all sharers low, no pulse", 32'(pulse), 0);
      route(6, 15);
      route(7, 15);
   endtask

   task automatic t_independent();
      route(8, 1);
      route(9, 3);
      src[8] = 1'b1;
      src[9] = 1'b1;
      tick(3);
      check("R9 both lines pulse", 32'(pulse), 32'h00A);
      tick(2);
      do_ack(9'h002);
      tick();
      check("R9 only acked line re-pulses", 32'(pulse), 32'h002);
      settle();
      route(8, 15);
      route(9, 15);
   endtask

   task automatic t_ack_idle();
      do_ack(9'h010);
      check("R10 ack on idle line", 32'(pulse), 0);
      tick();
      check("R10 still nothing", 32'(pulse), 0);
      route(10, 4);
      src[10] = 1'b1;
      tick(3);
      check("R10 line stayed idle", 32'(pulse), 32'h010);
      settle();
      route(10, 15);
   endtask

   initial begin
      tick(3);
      t_reset();
      t_single();
      t_mask();
      t_select();
      t_shared();
      t_independent();
      t_ack_idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule